// File: doc/BRIEF.md
# Paged Host Register File with Interrupt Status

This block is the host-side register access logic of a timer-clock peripheral. A host reaches it over a plain parallel bus: a 5-bit address, a write strobe with write data, and a read strobe with read data that is combinational. Address 0 always reaches the status register. Two bits of that register steer every other address to one of three 31-byte banks. Two of the banks are register blocks on the clock page. The third is a page of general-purpose RAM. The first register block also holds the interrupt enable register.

The status register gathers interrupt causes. The counter, timer and comparator logic sit outside this block and each pulse an event input. Four of the causes are sticky and are cleared by writing a one. One cause tracks a power-fail input and is cleared only when that input goes inactive. A single interrupt output is raised while any enabled cause is latched.

Top module: `prf_regfile`

## Requirements
- R1: A read at address 0 returns the status register, whatever the values of the page bit (bit 7) and the block bit (bit 6).
- R2: With status bit 7 = 1, addresses 1 to 31 reach 31 bytes of general-purpose RAM. These bytes are separate from both clock-page blocks.
- R3: With status bit 7 = 0, status bit 6 picks block 0 (value 0) or block 1 (value 1). Each block is 31 separate bytes at addresses 1 to 31. A write to address 0 loads bits 7:6 from write data bits 7:6.
- R4: Status bit 1 is 1 in the cycle after the cycle in which `pwrFail` is high, and 0 in the cycle after the cycle in which it is low. Bus writes never change it.
- R5: `evtIn[k]` high at a clock edge sets status bit k+2 (k = 0..3) from the next cycle on. This happens whatever the enable bits hold.
- R6: Reads never clear status bits. Writing a 0 to any of status bits 5:2 leaves that bit unchanged.
- R7: Writing a 1 to any of status bits 5:2 at address 0 clears that bit in the next cycle.
- R8: When an event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R9: Block 0 address 1 is the interrupt enable register. Its bits 5:1 enable status bits 5:1. `irq` is high exactly when some status bit in 5:1 and its enable bit are both 1.
- R10: Status bit 0 reads as the current `irq` level. Writes to bit 0 have no effect.
- R11: After reset, the status register, the enable register and every bank byte are 0. With `busRd` low, `busRdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from address and state |
| evtIn | input | 4 | Event pulses that set status bits 5:2 |
| pwrFail | input | 1 | Power-fail level, active high, drives status bit 1 |
| irq | output | 1 | Interrupt request, any enabled latched cause |

## Verification
Two functions can land on the same status bit in one cycle: an event that sets the bit, and a host write of one that clears it. The bench provokes this by pulsing an event input in the same cycle as a clearing write to address 0. It does this on purpose once, and again by chance during a long randomised stretch. The bench reference model applies set-over-clear priority. Its status value and interrupt level are compared with the read data and `irq` on every clock.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 5;
  localparam int N_BANKS  = 3;
  localparam int N_EVT    = 4;
  localparam int WORDS    = (1 << ADDR_W) - 1;
  localparam int PAGE_BIT = DATA_W - 1;
  localparam int BLK_BIT  = DATA_W - 2;
  localparam int EVT_LO   = 2;
  localparam int EVT_HI   = EVT_LO + N_EVT - 1;
  localparam int EN_ADDR  = 1;

  typedef enum logic [1:0] {
    BANK_CTRL = 2'd0,
    BANK_AUX  = 2'd1,
    BANK_RAM  = 2'd2
  } bank_e;

  typedef struct packed {
    logic              statusWr;
    logic              statusRd;
    logic              bankWr;
    logic              bankRd;
    bank_e             bank;
    logic [ADDR_W-1:0] index;
  } strobe_t;
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              pageSel,
  input  logic              blockSel,
  output strobe_t           strb
);
  logic atZero;

  assign atZero = (busAddr == '0);

  always_comb begin
    strb          = '0;
    strb.index    = busAddr;
    strb.statusWr = busWr & atZero;
    strb.statusRd = busRd & atZero;
    strb.bankWr   = busWr & ~atZero;
    strb.bankRd   = busRd & ~atZero;
    if (pageSel)       strb.bank = BANK_RAM;
    else if (blockSel) strb.bank = BANK_AUX;
    else               strb.bank = BANK_CTRL;
  end
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [N_EVT-1:0]  evtIn,
  input  logic              pwrFail,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              pageSel,
  output logic              blockSel
);
  logic [EVT_HI:1]    latchedQ;
  logic               pageQ;
  logic               blockQ;
  logic [EVT_HI:1]    intEn;
  logic [N_EVT-1:0]   clrMask;
  logic [DATA_W-1:0]  bankRdData [N_BANKS];

  // Storage banks: one array per bank, so each has a single driver
  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] words [1:WORDS];
    logic              hit;

    assign hit = strb.bankWr && (strb.bank == bank_e'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 1; i <= WORDS; i++) words[i] <= '0;
      end else if (hit) begin
        words[strb.index] <= wrData;
      end
    end

    assign bankRdData[b] = (strb.index == '0) ? '0 : words[strb.index];

    if (b == int'(BANK_CTRL)) begin : g_en
      assign intEn = words[EN_ADDR][EVT_HI:1];
    end
  end

  assign clrMask = strb.statusWr ? wrData[EVT_HI:EVT_LO] : '0;

  // Status: set has priority over write-one-to-clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchedQ <= '0;
      pageQ    <= 1'b0;
      blockQ   <= 1'b0;
    end else begin
      latchedQ[1]             <= pwrFail;
      latchedQ[EVT_HI:EVT_LO] <= evtIn | (latchedQ[EVT_HI:EVT_LO] & ~clrMask);
      if (strb.statusWr) begin
        pageQ  <= wrData[PAGE_BIT];
        blockQ <= wrData[BLK_BIT];
      end
    end
  end

  assign irq      = |(latchedQ & intEn);
  assign pageSel  = pageQ;
  assign blockSel = blockQ;

  always_comb begin
    rdData = '0;
    if (strb.statusRd) begin
      rdData[PAGE_BIT]      = pageQ;
      rdData[BLK_BIT]       = blockQ;
      rdData[EVT_HI:1]      = latchedQ;
      rdData[0]             = irq;
    end else if (strb.bankRd) begin
      rdData = bankRdData[strb.bank];
    end
  end

  // Events latch regardless of enables (R5)
  assert_evt_latch_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|evtIn) |=> ((latchedQ[EVT_HI:EVT_LO] & $past(evtIn)) == $past(evtIn)));

  // Event beats a same-cycle clear (R8)
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusWr && (|(evtIn & wrData[EVT_HI:EVT_LO])))
      |=> ((latchedQ[EVT_HI:EVT_LO] & $past(evtIn)) == $past(evtIn)));

  // Write of one clears when no event competes (R7)
  assert_w1c_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statusWr && evtIn == '0)
      |=> ((latchedQ[EVT_HI:EVT_LO] & $past(wrData[EVT_HI:EVT_LO])) == '0));

  // No clear without a status write (R6)
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusWr |=> ((latchedQ[EVT_HI:EVT_LO] & $past(latchedQ[EVT_HI:EVT_LO]))
                        == $past(latchedQ[EVT_HI:EVT_LO])));

  // Power-fail bit follows the pin (R4)
  assert_pfail_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    pwrFail |=> latchedQ[1]);
  assert_pfail_clr_R4: assert property (@(posedge clk) disable iff (!rstN)
    !pwrFail |=> !latchedQ[1]);

  // Page and block bits hold without a status write (R3)
  assert_page_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.statusWr |=> $stable({pageQ, blockQ}));
endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [N_EVT-1:0]  evtIn,
  input  logic              pwrFail,
  output logic              irq
);
  strobe_t strb;
  logic    pageSel;
  logic    blockSel;

  prf_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .pageSel (pageSel),
    .blockSel(blockSel),
    .strb    (strb)
  );

  prf_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (busWrData),
    .evtIn   (evtIn),
    .pwrFail (pwrFail),
    .rdData  (busRdData),
    .irq     (irq),
    .pageSel (pageSel),
    .blockSel(blockSel)
  );
endmodule

// File: tb/prf_regfile_tb.sv
module prf_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [3:0] evtIn = '0;
  logic       pwrFail = 1'b0;
  logic       irq;

  int vectors = 0;
  int miscompares = 0;

  // Reference model state
  logic [7:0] mMem [3][32];
  logic [5:1] mStat;
  logic       mPage;
  logic       mBlk;

  always #(CLK_PERIOD/2) clk = ~clk;

  prf_regfile u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWrData(busWrData), .busRdData(busRdData), .evtIn(evtIn),
    .pwrFail(pwrFail), .irq(irq)
  );

  function automatic logic expIrq();
    return |(mStat & mMem[0][1][5:1]);
  endfunction

  function automatic logic [7:0] expRead();
    int bank;
    if (!busRd || !rstN && 0) return 8'h00;
    if (busAddr == 0) return {mPage, mBlk, mStat, expIrq()};
    bank = mPage ? 2 : (mBlk ? 1 : 0);
    return mMem[bank][busAddr];
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 3; b++)
        for (int i = 0; i < 32; i++) mMem[b][i] = 8'h00;
      mStat = '0; mPage = 1'b0; mBlk = 1'b0;
    end else begin
      logic [3:0] clr;
      int bank;
      clr  = (busWr && busAddr == 0) ? busWrData[5:2] : 4'h0;
      bank = mPage ? 2 : (mBlk ? 1 : 0);
      if (busWr) begin
        if (busAddr == 0) begin
          mPage = busWrData[7];
          mBlk  = busWrData[6];
        end else begin
          mMem[bank][busAddr] = busWrData;
        end
      end
      mStat[5:2] = evtIn | (mStat[5:2] & ~clr);
      mStat[1]   = pwrFail;
    end
  end

  task automatic check(string tag);
    logic [7:0] eD;
    logic       eI;
    eD = expRead();
    eI = expIrq();
    vectors++;
    if (busRdData !== eD || irq !== eI) begin
      miscompares++;
      $display("FAIL %s: rdData=%h irq=%b expected rdData=%h irq=%b",
               tag, busRdData, irq, eD, eI);
    end
  endtask

  task automatic step(logic [4:0] a, bit w, bit r, logic [7:0] d,
                      logic [3:0] e, bit pf, string tag);
    @(negedge clk);
    busAddr = a; busWr = w; busRd = r; busWrData = d; evtIn = e; pwrFail = pf;
    #1;
    check(tag);
  endtask

  task automatic rd(logic [4:0] a, string tag);
    step(a, 0, 1, 8'h00, 4'h0, 0, tag);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d, string tag);
    step(a, 1, 0, d, 4'h0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R11 reset state
    rd(5'd0, "R11");
    rd(5'd1, "R11");
    @(negedge clk); rstN = 1'b1;
    rd(5'd0, "R11");
    rd(5'd9, "R11");
    step(5'd0, 0, 0, 8'h00, 4'h0, 0, "R11");

    // R3 block selection and distinct storage
    wr(5'd5, 8'hA5, "R3");
    wr(5'd0, 8'h40, "R3");
    wr(5'd5, 8'h3C, "R3");
    rd(5'd5, "R3");
    rd(5'd0, "R1");
    wr(5'd0, 8'h00, "R3");
    rd(5'd5, "R3");

    // R2 RAM page
    wr(5'd0, 8'h80, "R2");
    wr(5'd5, 8'h77, "R2");
    wr(5'd31, 8'hE1, "R2");
    rd(5'd31, "R2");
    rd(5'd5, "R2");
    rd(5'd0, "R1");
    wr(5'd0, 8'hC0, "R1");
    rd(5'd0, "R1");
    wr(5'd0, 8'h00, "R3");
    rd(5'd5, "R3");
    rd(5'd31, "R3");

    // R5 events latch with enables off
    step(5'd0, 0, 1, 8'h00, 4'b0101, 0, "R5");
    rd(5'd0, "R5");
    rd(5'd0, "R6");
    wr(5'd0, 8'h00, "R6");
    rd(5'd0, "R6");

    // R9 enable register, R10 bit 0
    wr(5'd1, 8'h3E, "R9");
    rd(5'd0, "R10");
    wr(5'd0, 8'h01, "R10");
    rd(5'd0, "R10");

    // R7 clear by one
    wr(5'd0, 8'h04, "R7");
    rd(5'd0, "R7");
    wr(5'd0, 8'h10, "R7");
    rd(5'd0, "R9");

    // R8 event against clear in one cycle
    step(5'd0, 0, 0, 8'h00, 4'b0100, 0, "R8");
    step(5'd0, 1, 0, 8'h10, 4'b0100, 0, "R8");
    rd(5'd0, "R8");

    // R4 power fail
    step(5'd0, 0, 1, 8'h00, 4'h0, 1, "R4");
    step(5'd0, 1, 0, 8'h02, 4'h0, 1, "R4");
    step(5'd0, 0, 1, 8'h00, 4'h0, 1, "R4");
    wr(5'd1, 8'h02, "R9");
    step(5'd0, 0, 1, 8'h00, 4'h0, 1, "R9");
    step(5'd0, 0, 1, 8'h00, 4'h0, 0, "R4");
    rd(5'd0, "R4");

    // Mixed traffic, compared every cycle
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a;
      bit         w;
      logic [3:0] e;
      a = 5'($urandom_range(0, 31));
      w = ($urandom % 3) == 0;
      e = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      step(a, w, !w, 8'($urandom), e, (i % 37) < 6, "R1");
    end

    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule